// File: doc/BRIEF.md
# Jump Target and Link Unit

This block resolves the unconditional control transfers of a 32-bit core that runs one delay-slot instruction after each jump. It takes the address of the delay slot (`next_pc`), a register operand, an immediate operand, a flag saying the link destination is the zero register, and a one-hot select that names the jump kind. From these inputs it forms the jump target and the return address to be written back.

The block supports three jump kinds. A register jump takes the whole register value as its target. A region jump keeps the top four bits of `next_pc` and fills the rest from a 26-bit word index, so its reach is a 256 MB aligned region. A relative jump adds the immediate to `next_pc`. The return address is the word after the delay slot. Its write enable is dropped when the destination is the zero register. A select that is not one-hot is flagged as illegal.

All results are captured on a valid strobe and are presented one clock later with their own valid flag. They hold their values until the next strobe.

Top module: `jtl_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `out_valid`, `target`, `link_val`, `link_we` and `illegal` are all zero.
- R2: `out_valid` is high in the cycle after a cycle with `in_valid` high and is low after a cycle with `in_valid` low.
- R3: With `kind_sel` = 3'b001 (register jump), `target` equals `reg_val`.
- R4: With `kind_sel` = 3'b010 (region jump), `target` = {`next_pc`[31:28], `imm_val`[25:0], 2'b00}. Bits 31:26 of `imm_val` have no effect.
- R5: With `kind_sel` = 3'b100 (relative jump), `target` = (`next_pc` + `imm_val`) mod 2^32.
- R6: For a legal select, `link_val` = (`next_pc` + 4) mod 2^32.
- R7: For a legal select, `link_we` is high when `dest_zero` is 0 and low when `dest_zero` is 1. The value of `link_val` does not depend on `dest_zero`.
- R8: A `kind_sel` that has zero bits set, or more than one bit set, gives `illegal` = 1, `link_we` = 0, `target` = 0 and `link_val` = 0. A legal select gives `illegal` = 0.
- R9: A cycle with `in_valid` low leaves `target`, `link_val`, `link_we` and `illegal` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe that captures a jump request |
| next_pc | input | 32 | Address of the delay-slot instruction |
| reg_val | input | 32 | Register operand (register-jump target) |
| imm_val | input | 32 | Immediate: word index in bits 25:0 for region jumps, byte offset for relative jumps |
| dest_zero | input | 1 | High when the link destination is the zero register |
| kind_sel | input | 3 | One-hot jump kind: bit0 register, bit1 region, bit2 relative |
| out_valid | output | 1 | Results are from the request of the previous cycle |
| target | output | 32 | Jump target address |
| link_val | output | 32 | Return address to write back |
| link_we | output | 1 | Write enable for the return address |
| illegal | output | 1 | Select was not one-hot |

## Verification
Every result passes through exactly one register stage. A wrong target mux leg, a bad region split or a dropped carry therefore shows at `target` in the cycle right after the strobe. An error in the select check shows as a wrong `illegal` flag, or as a nonzero `target`/`link_val` on a rejected request, in that same cycle. A load enable that ignores `in_valid` shows as outputs that change during idle cycles, one cycle after the inputs change. Directed cases place carries at the 32-bit wrap point and set the ignored high index bits to ones, so errors in those places cannot hide behind zero operands.

// File: rtl/jtl_pkg.sv
package jtl_pkg;
  localparam int NUM_KINDS   = 3;
  localparam int KIND_REG    = 0;
  localparam int KIND_REGION = 1;
  localparam int KIND_DIRECT = 2;
endpackage

// File: rtl/jtl_select_check.sv
module jtl_select_check #(
  parameter int N = jtl_pkg::NUM_KINDS
) (
  input  logic [N-1:0] sel,
  output logic         legal
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) ones = ones + CW'(sel[i]);
    legal = (ones == CW'(1));
  end
endmodule

// File: rtl/jtl_target_form.sv
module jtl_target_form #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 26
) (
  input  logic [XLEN-1:0]                 next_pc,
  input  logic [XLEN-1:0]                 reg_val,
  input  logic [XLEN-1:0]                 imm_val,
  input  logic [jtl_pkg::NUM_KINDS-1:0]   sel,
  output logic [XLEN-1:0]                 target
);
  import jtl_pkg::*;
  localparam int REGION_W = XLEN - IDX_W - 2;

  logic [XLEN-1:0] cand [NUM_KINDS];

  genvar k;
  generate
    for (k = 0; k < NUM_KINDS; k++) begin : g_kind
      if (k == KIND_REG) begin : g_reg
        assign cand[k] = reg_val;
      end else if (k == KIND_REGION) begin : g_region
        assign cand[k] = {next_pc[XLEN-1 -: REGION_W], imm_val[IDX_W-1:0], 2'b00};
      end else begin : g_direct
        assign cand[k] = next_pc + imm_val;
      end
    end
  endgenerate

  always_comb begin
    target = '0;
    for (int i = 0; i < NUM_KINDS; i++)
      target = target | (cand[i] & {XLEN{sel[i]}});
  end
endmodule

// File: rtl/jtl_link_form.sv
module jtl_link_form #(
  parameter int XLEN      = 32,
  parameter int LINK_STEP = 4
) (
  input  logic [XLEN-1:0] next_pc,
  input  logic            dest_zero,
  input  logic            legal,
  output logic [XLEN-1:0] link_val,
  output logic            link_we
);
  always_comb begin
    link_val = legal ? next_pc + XLEN'(LINK_STEP) : '0;
    link_we  = legal & ~dest_zero;
  end
endmodule

// File: rtl/jtl_unit.sv
module jtl_unit #(
  parameter int XLEN      = 32,
  parameter int IDX_W     = 26,
  parameter int LINK_STEP = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  input  logic [XLEN-1:0]               next_pc,
  input  logic [XLEN-1:0]               reg_val,
  input  logic [XLEN-1:0]               imm_val,
  input  logic                          dest_zero,
  input  logic [jtl_pkg::NUM_KINDS-1:0] kind_sel,
  output logic                          out_valid,
  output logic [XLEN-1:0]               target,
  output logic [XLEN-1:0]               link_val,
  output logic                          link_we,
  output logic                          illegal
);
  import jtl_pkg::*;

  logic            legal;
  logic [XLEN-1:0] tgt_raw;
  logic [XLEN-1:0] link_raw;
  logic            we_raw;

  jtl_select_check #(.N(NUM_KINDS)) u_check (
    .sel   (kind_sel),
    .legal (legal)
  );

  jtl_target_form #(.XLEN(XLEN), .IDX_W(IDX_W)) u_target (
    .next_pc (next_pc),
    .reg_val (reg_val),
    .imm_val (imm_val),
    .sel     (kind_sel),
    .target  (tgt_raw)
  );

  jtl_link_form #(.XLEN(XLEN), .LINK_STEP(LINK_STEP)) u_link (
    .next_pc   (next_pc),
    .dest_zero (dest_zero),
    .legal     (legal),
    .link_val  (link_raw),
    .link_we   (we_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      target    <= '0;
      link_val  <= '0;
      link_we   <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        target   <= legal ? tgt_raw : '0;
        link_val <= link_raw;
        link_we  <= we_raw;
        illegal  <= ~legal;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_reg_target_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind_sel == 3'b001) |=> target == $past(reg_val));
  assert_region_align_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && kind_sel == 3'b010) |=> target[1:0] == 2'b00);
  assert_link_step_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && $onehot(kind_sel)) |=> link_val == $past(next_pc) + XLEN'(LINK_STEP));
  assert_link_suppress_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dest_zero) |=> !link_we);
  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && illegal) |-> (!link_we && target == '0 && link_val == '0));
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(target) && $stable(link_val) && $stable(link_we) && $stable(illegal)));
endmodule

// File: tb/tb_jtl_unit.sv
module tb_jtl_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] next_pc, reg_val, imm_val;
  logic        dest_zero;
  logic [2:0]  kind_sel;
  logic        out_valid, link_we, illegal;
  logic [31:0] target, link_val;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  jtl_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .next_pc(next_pc),
    .reg_val(reg_val), .imm_val(imm_val), .dest_zero(dest_zero),
    .kind_sel(kind_sel), .out_valid(out_valid), .target(target),
    .link_val(link_val), .link_we(link_we), .illegal(illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample at following negedge
  task automatic issue(input logic [31:0] pc, input logic [31:0] rv,
                       input logic [31:0] iv, input logic dz, input logic [2:0] s);
    next_pc = pc; reg_val = rv; imm_val = iv; dest_zero = dz; kind_sel = s;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "out_valid", {31'b0, out_valid}, 32'h0);
    chk("R1", "target", target, 32'h0);
    chk("R1", "link_val", link_val, 32'h0);
    chk("R1", "link_we", {31'b0, link_we}, 32'h0);
    chk("R1", "illegal", {31'b0, illegal}, 32'h0);
  endtask

  task automatic t_register_jump;
    issue(32'h0040_1004, 32'hDEAD_BEE0, 32'h1234_5678, 1'b0, 3'b001);
    chk("R2", "out_valid", {31'b0, out_valid}, 32'h1);
    chk("R3", "target", target, 32'hDEAD_BEE0);
    chk("R6", "link_val", link_val, 32'h0040_1008);
    chk("R7", "link_we", {31'b0, link_we}, 32'h1);
    chk("R8", "illegal", {31'b0, illegal}, 32'h0);
    issue(32'h8000_0000, 32'h0000_0004, 32'h0, 1'b0, 3'b001);
    chk("R3", "target2", target, 32'h0000_0004);
  endtask

  task automatic t_region_jump;
    issue(32'hA123_4560, 32'h0, 32'hFC00_0001, 1'b0, 3'b010);
    chk("R4", "target hi index bits ignored", target, 32'hA000_0004);
    issue(32'h3FFF_FFFC, 32'hFFFF_FFFF, 32'h03FF_FFFF, 1'b1, 3'b010);
    chk("R4", "target full index", target, 32'h3FFF_FFFC);
    chk("R7", "link_we suppressed", {31'b0, link_we}, 32'h0);
    chk("R7", "link_val kept", link_val, 32'h4000_0000);
  endtask

  task automatic t_direct_jump;
    issue(32'h0000_1000, 32'h0, 32'hFFFF_FFF0, 1'b0, 3'b100);
    chk("R5", "negative offset", target, 32'h0000_0FF0);
    issue(32'hFFFF_FFFC, 32'h0, 32'h0000_0010, 1'b0, 3'b100);
    chk("R5", "wrap target", target, 32'h0000_000C);
    chk("R6", "wrap link", link_val, 32'h0000_0000);
  endtask

  task automatic t_illegal;
    issue(32'h0000_2000, 32'h1111_1111, 32'h4, 1'b0, 3'b000);
    chk("R8", "illegal none", {31'b0, illegal}, 32'h1);
    chk("R8", "target none", target, 32'h0);
    chk("R8", "link_val none", link_val, 32'h0);
    chk("R8", "link_we none", {31'b0, link_we}, 32'h0);
    issue(32'h0000_2000, 32'h1111_1111, 32'h4, 1'b0, 3'b101);
    chk("R8", "illegal two-hot", {31'b0, illegal}, 32'h1);
    chk("R8", "target two-hot", target, 32'h0);
    issue(32'h0000_2000, 32'h0, 32'h4, 1'b0, 3'b111);
    chk("R8", "illegal three-hot", {31'b0, illegal}, 32'h1);
  endtask

  task automatic t_hold;
    issue(32'h0000_3000, 32'h5555_5550, 32'h0, 1'b0, 3'b001);
    next_pc = 32'h9999_9999; reg_val = 32'h7777_7777; kind_sel = 3'b000; dest_zero = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R2", "out_valid drops", {31'b0, out_valid}, 32'h0);
    chk("R9", "target held", target, 32'h5555_5550);
    chk("R9", "link_val held", link_val, 32'h0000_3004);
    chk("R9", "link_we held", {31'b0, link_we}, 32'h1);
    chk("R9", "illegal held", {31'b0, illegal}, 32'h0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; next_pc = '0; reg_val = '0; imm_val = '0;
    dest_zero = 1'b0; kind_sel = 3'b001;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_register_jump();
    t_region_jump();
    t_direct_jump();
    t_illegal();
    t_hold();
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule